// File: doc/BRIEF.md
# Step attenuator control interface

This block is the digital front end that sets a 6-bit step attenuator. It produces a registered attenuation code for the switch array. The code comes from one of two sources, chosen by a mode input. In parallel mode the code comes from six pins. In serial mode it is built up bit by bit from a data line, clocked by a serial clock and committed by a latch-enable strobe. All pins are sampled on the system clock `clk_i`. Serial-clock and latch-enable edges are detected in that clock domain.

Parallel mode has two behaviours. While latch enable is high, the output tracks the pins. On the falling edge of latch enable the pins are captured, and they are then held. After power-up, modelled by releasing `rst_ni`, the block loads a starting code. It takes this code either from the parallel pins or from a four-entry preset table, indexed by two power-up select pins, depending on the mode and latch-enable levels at that moment.

The switch array cannot follow code changes faster than a fixed rate. For this reason the output register enforces a minimum spacing of `MIN_GAP` clock cycles between changes. A request that arrives during the hold-off is kept, and the latest one is applied when the hold-off ends. The latch-enable input is pulled up off chip, so its sampled copy resets to 1.

Top module: `step_atten_ctrl`

## Requirements
- R1: The code is binary with code = 2 × attenuation in dB: bit 0 weighs 0.5 dB, bit 1 1 dB, bit 2 2 dB, bit 3 4 dB, bit 4 8 dB and bit 5 16 dB. While `rst_ni` is low, `atten_code_o` is 0.
- R2: After `rst_ni` rises, the pins are registered at the first `clk_i` edge. The start-up code appears on `atten_code_o` after the second edge, and the output is still 0 after the first edge.
- R3: If start-up sees `serial_sel_i`=0 and `latch_en_i`=0, the code is taken from the preset table indexed by `pup_sel_i`. The default table is 2'b00→0 (0 dB), 2'b01→16 (8 dB), 2'b10→32 (16 dB) and 2'b11→63 (31.5 dB).
- R4: For every other mode and latch-enable combination at start-up, the code equals `par_code_i`.
- R5: With `serial_sel_i`=1, each rising edge of `sclk_i` shifts `sdata_i` into a 6-bit register, most significant bit first. A rising edge of `latch_en_i` copies that register to the output, and `par_code_i` has no effect.
- R6: In serial mode, shifting without a latch-enable rising edge leaves `atten_code_o` unchanged.
- R7: With `serial_sel_i`=0 and `latch_en_i` high, the output follows `par_code_i` two `clk_i` edges after a pin change, provided no hold-off is pending.
- R8: With `serial_sel_i`=0, the falling edge of `latch_en_i` captures `par_code_i`. Later pin changes are ignored while latch enable stays low.
- R9: Successive changes of `atten_code_o` are at least `MIN_GAP` clock cycles apart. A request made during the hold-off is applied when the hold-off ends, and the latest such request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| serial_sel_i | input | 1 | 1 = serial control, 0 = parallel control |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock (sampled) |
| latch_en_i | input | 1 | Latch enable (sampled, pulled up externally) |
| pup_sel_i | input | 2 | Power-up preset select |
| par_code_i | input | 6 | Parallel attenuation code pins |
| atten_code_o | output | 6 | Registered code to the switch array |

## Verification
The bench builds the block with `MIN_GAP` = 4 and the default preset table. The short hold-off lets all 64 codes be swept through the serial path and through the parallel direct path in a few thousand cycles. It also makes the deferral of requests during hold-off, including a latched capture that arrives mid hold-off, observable within a handful of edges. Each combination of start-up mode and latch-enable level, and all four preset selections, is reached by re-applying reset.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned CODE_W     = 6;
  localparam int unsigned PUP_W      = 2;
  localparam int unsigned NUM_PRESET = 1 << PUP_W;

  // start-up picks the preset table only for parallel mode with latch low
  function automatic logic use_preset(input logic serial, input logic le);
    return !serial && !le;
  endfunction
endpackage

// File: rtl/sat_pin_sync.sv
module sat_pin_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sat_shift_reg.sv
module sat_shift_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sclk_i,
  input  logic         sdata_i,
  output logic [W-1:0] word_o
);
  logic sclk_prev_q;
  logic [W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      word_q      <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      if (en_i && sclk_i && !sclk_prev_q) word_q <= {word_q[W-2:0], sdata_i};
    end
  end

  assign word_o = word_q;

  // R5: no serial clock edge, no shift
  p_shift_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i == sclk_prev_q) |=> $stable(word_o));
endmodule

// File: rtl/sat_rate_gate.sv
module sat_rate_gate #(
  parameter int unsigned W       = 6,
  parameter int unsigned MIN_GAP = 4000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_v_i,
  input  logic [W-1:0] req_code_i,
  output logic [W-1:0] code_o
);
  localparam int unsigned GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP - 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] gap_q;
  logic             pend_v_q;
  logic [W-1:0]     pend_code_q, code_q;
  logic             want_v, apply;
  logic [W-1:0]     want_code;

  always_comb begin
    want_v    = req_v_i | pend_v_q;
    want_code = req_v_i ? req_code_i : pend_code_q;
    apply     = want_v && (gap_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      pend_v_q    <= 1'b0;
      pend_code_q <= '0;
      code_q      <= '0;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - GAP_W'(1);
      if (apply) begin
        pend_v_q <= 1'b0;
        if (want_code != code_q) begin
          code_q <= want_code;
          gap_q  <= GAP_LOAD;
        end
      end else if (req_v_i) begin
        pend_v_q    <= 1'b1;
        pend_code_q <= req_code_i;
      end
    end
  end

  assign code_o = code_q;

  // independent spacing monitor for the assertion below
  logic [GAP_W-1:0] since_q;
  logic [W-1:0]     code_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q     <= GAP_MAX;
      code_prev_q <= '0;
    end else begin
      code_prev_q <= code_q;
      if (code_q != code_prev_q) since_q <= GAP_W'(1);
      else if (since_q < GAP_MAX) since_q <= since_q + GAP_W'(1);
    end
  end

  p_min_spacing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != code_prev_q) |-> (since_q >= GAP_MAX));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int unsigned CODE_W  = sat_pkg::CODE_W,
  parameter int unsigned MIN_GAP = 4000,
  parameter logic [sat_pkg::NUM_PRESET-1:0][CODE_W-1:0] PRESETS =
    {CODE_W'(63), CODE_W'(32), CODE_W'(16), CODE_W'(0)}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      serial_sel_i,
  input  logic                      sdata_i,
  input  logic                      sclk_i,
  input  logic                      latch_en_i,
  input  logic [sat_pkg::PUP_W-1:0] pup_sel_i,
  input  logic [CODE_W-1:0]         par_code_i,
  output logic [CODE_W-1:0]         atten_code_o
);
  localparam int unsigned PUP_W = sat_pkg::PUP_W;
  localparam int unsigned IN_W  = 4 + PUP_W + CODE_W;
  // latch enable is pulled up, so its sampled copy resets high
  localparam logic [IN_W-1:0] IN_RST = {3'b000, 1'b1, PUP_W'(0), CODE_W'(0)};

  logic [IN_W-1:0]   in_s;
  logic              serial_s, sdata_s, sclk_s, le_s;
  logic [PUP_W-1:0]  pup_s;
  logic [CODE_W-1:0] par_s, shift_word, req_code;
  logic              le_prev_q, req_v;
  logic [1:0]        boot_cnt_q;

  sat_pin_sync #(.W(IN_W), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({serial_sel_i, sdata_i, sclk_i, latch_en_i, pup_sel_i, par_code_i}),
    .q_o   (in_s)
  );
  assign {serial_s, sdata_s, sclk_s, le_s, pup_s, par_s} = in_s;

  sat_shift_reg #(.W(CODE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (serial_s && (boot_cnt_q == 2'd0)),
    .sclk_i (sclk_s),
    .sdata_i(sdata_s),
    .word_o (shift_word)
  );

  // boot: 2 = pins being registered, 1 = load start-up code, 0 = running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_cnt_q <= 2'd2;
      le_prev_q  <= 1'b1;
    end else begin
      le_prev_q <= le_s;
      if (boot_cnt_q != 2'd0) boot_cnt_q <= boot_cnt_q - 2'd1;
    end
  end

  always_comb begin
    req_v    = 1'b0;
    req_code = par_s;
    if (boot_cnt_q == 2'd1) begin
      req_v = 1'b1;
      if (sat_pkg::use_preset(serial_s, le_s)) req_code = PRESETS[pup_s];
    end else if (boot_cnt_q == 2'd0) begin
      if (serial_s) begin
        req_v    = le_s && !le_prev_q;
        req_code = shift_word;
      end else begin
        // direct while high, plus one capture on the falling edge
        req_v = le_s || le_prev_q;
      end
    end
  end

  sat_rate_gate #(.W(CODE_W), .MIN_GAP(MIN_GAP)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_v_i   (req_v),
    .req_code_i(req_code),
    .code_o    (atten_code_o)
  );

  p_boot_preset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_cnt_q == 2'd1 && !serial_s && !le_s) |=> (atten_code_o == PRESETS[$past(pup_s)]));

  p_boot_pins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_cnt_q == 2'd1 && (serial_s || le_s)) |=> (atten_code_o == $past(par_s)));
endmodule

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
  localparam int GAP = 4;

  logic       clk = 1'b0;
  logic       rst_n, serial, sdata, sclk, le;
  logic [1:0] pup;
  logic [5:0] par, code;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  step_atten_ctrl #(.MIN_GAP(GAP)) u_step_atten_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .serial_sel_i(serial), .sdata_i(sdata),
    .sclk_i(sclk), .latch_en_i(le), .pup_sel_i(pup), .par_code_i(par),
    .atten_code_o(code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] preset_exp(input logic [1:0] p);
    real db;
    case (p)
      2'd0: db = 0.0;
      2'd1: db = 8.0;
      2'd2: db = 16.0;
      default: db = 31.5;
    endcase
    return 6'($rtoi(db * 2.0));
  endfunction

  // R9 spacing monitor at the ports
  int since = GAP;
  logic [5:0] last = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      since = GAP;
      last  = code;
    end else if (code !== last) begin
      checks++;
      if (since < GAP) begin
        errors++;
        $display("FAIL R9 spacing: actual=%0d expected>=%0d", since, GAP);
      end
      since = 1;
      last  = code;
    end else if (since < GAP) since++;
  end

  task automatic boot(input logic ser, input logic le_v, input logic [1:0] pup_v,
                      input logic [5:0] par_v, input logic [5:0] exp, input string tag);
    @(negedge clk);
    rst_n = 1'b0; serial = ser; le = le_v; pup = pup_v; par = par_v; sclk = 1'b0; sdata = 1'b0;
    tick(2);
    chk("R1 reset code", code, 6'd0);
    rst_n = 1'b1;
    tick(1);
    chk("R2 code after first edge", code, 6'd0);
    tick(1);
    chk(tag, code, exp);
    tick(GAP + 2);
  endtask

  task automatic send_word(input logic [5:0] w, input logic [5:0] prev);
    par = ~w;
    for (int i = 5; i >= 0; i--) begin
      sdata = w[i];
      tick(1);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
      tick(2);
    end
    chk("R6 no change before latch", code, prev);
    le = 1'b1;
    tick(3);
    chk("R5 serial word latched", code, w);
    le = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; serial = 1'b0; sdata = 1'b0; sclk = 1'b0; le = 1'b1; pup = '0; par = '0;
    tick(3);

    // R3 preset table
    for (int p = 0; p < 4; p++)
      boot(1'b0, 1'b0, 2'(p), 6'h2A ^ 6'(p), preset_exp(2'(p)), "R3 preset start-up");
    // R4 pin start-up
    boot(1'b1, 1'b1, 2'd3, 6'h0C, 6'h0C, "R4 serial le high start-up");
    boot(1'b0, 1'b1, 2'd1, 6'h33, 6'h33, "R4 parallel le high start-up");
    boot(1'b1, 1'b0, 2'd2, 6'h15, 6'h15, "R4 serial le low start-up");

    // R5/R6 serial sweep
    begin
      logic [5:0] prev = 6'h15;
      for (int w = 0; w < 64; w++) begin
        send_word(6'(w), prev);
        prev = 6'(w);
      end
    end

    // R7 direct sweep
    serial = 1'b0; le = 1'b1;
    for (int v = 0; v < 64; v++) begin
      par = 6'(v);
      tick(2 * GAP + 2);
      chk("R7 direct follow", code, 6'(v));
    end
    par = 6'h2D;
    tick(1);
    chk("R7 latency one edge", code, 6'd63);
    tick(1);
    chk("R7 latency two edges", code, 6'h2D);
    tick(2 * GAP + 2);

    // R8 latched
    par = 6'h11;
    tick(2 * GAP + 2);
    par = 6'h22; le = 1'b0;
    tick(2 * GAP + 2);
    chk("R8 capture on fall", code, 6'h22);
    for (int v = 0; v < 4; v++) begin
      par = 6'(v * 13 + 1);
      tick(2 * GAP + 2);
      chk("R8 pins ignored while low", code, 6'h22);
    end
    le = 1'b1;
    tick(2 * GAP + 2);
    chk("R7 direct resumes", code, 6'(3 * 13 + 1));

    // R9 hold-off and deferral
    par = 6'h05;
    tick(2 * GAP + 2);
    par = 6'h3A;
    tick(2);
    chk("R9 first change", code, 6'h3A);
    par = 6'h07;
    tick(2);
    chk("R9 held during hold-off", code, 6'h3A);
    tick(4);
    chk("R9 applied after hold-off", code, 6'h07);
    tick(2 * GAP + 2);
    par = 6'h10;
    tick(2);
    chk("R9 change before capture", code, 6'h10);
    par = 6'h2B; le = 1'b0;
    tick(1);
    par = 6'h01;
    tick(8);
    chk("R9 pending capture applied", code, 6'h2B);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule